// File: doc/BRIEF.md
# Status-Override LED Driver

This block is a small APB slave that drives a bank of eight LEDs. In its normal mode the LEDs show a byte that software writes into a data register. Setting a single source-select bit hands the LEDs over to eight processor status lines. Each of these lines passes through its own pulse stretcher, so a one-cycle event still shows as a visible flash.

Software reaches two registers at fixed word offsets. These are the LED data register and the source-select control register. Every other offset in the slave's window reads as zero and ignores writes. The stretchers run all the time, whichever source is selected. A switch to override mode therefore shows any flash that is already in progress. The stretch length is a parameter, and it is long by default so that the eye can see a single-cycle pulse.

Top module: `ledovr_top`

## Requirements
- R1: The LED data register holds 8 bits, written from pwdata[7:0] at word offset 0x0C, and resets to 0x00. While the source select is 0, led_o equals this register, and a 1 bit lights its LED.
- R2: A read of offset 0x0C returns the last value written in bits 7:0, with bits 31:8 zero, whatever the source select is.
- R3: The control register sits at offset 0x14. Bit 0 is the source select (0 = data register, 1 = status lines) and resets to 0. Reads return it in bit 0 with every other bit zero.
- R4: While the source select is 1, led_o[i] is the stretched form of status_i[i]. The lines map as follows: 7 sleeping, 6 deep sleep, 5 halted, 4 lockup, 3 system reset request, 2 event transmit, 1 wakeup, 0 debug restarted.
- R5: A stretched line is high in every cycle its input is high. After the input falls, it stays high for exactly STRETCH_CYCLES more cycles and then goes low.
- R6: A new pulse that arrives during a stretch restarts that line's full STRETCH_CYCLES hold from the new pulse's falling edge.
- R7: A read of any offset other than 0x0C and 0x14 returns zero, and a write to such an offset changes neither register.
- R8: A write takes effect only in the access phase (psel, penable and pwrite all high). pready is always 1, so the slave adds no wait states.
- R9: The stretchers run in both modes. A pulse seen while the source select is 0 shows on the LEDs if override mode is selected before its stretch ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and stretcher clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | ADDR_W | APB byte address within the slave window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| status_i | input | NUM_LEDS | Processor status lines, mapped as in R4 |
| led_o | output | NUM_LEDS | LED drives, 1 = lit |

## Verification
The assertions assume APB transfers that follow the protocol. This means a setup cycle with psel high and penable low, then one access cycle, with the address and data held steady across both cycles. The bench drives every transfer through one task that keeps to this sequence. The status lines are treated as synchronous to clk. The bench changes them only at the falling edge, and mostly sparsely, so that stretches both expire and get restarted. The bench shortens the stretch length through its parameter so that whole stretches fit in a short run.

// File: rtl/ledovr_pkg.sv
package ledovr_pkg;

  localparam int unsigned BUS_W = 32;

  typedef enum logic {
    SRC_SOFT   = 1'b0,
    SRC_STATUS = 1'b1
  } led_src_e;

  // Zero-extend a narrow field onto the read bus.
  function automatic logic [BUS_W-1:0] widen(input logic [BUS_W-1:0] v, input int unsigned w);
    logic [BUS_W-1:0] m;
    m = (w >= BUS_W) ? {BUS_W{1'b1}} : ((BUS_W'(1) << w) - BUS_W'(1));
    return v & m;
  endfunction

  // Next value of a stretch counter: reload on input, else count toward zero.
  function automatic int unsigned stretch_next(input logic level, input int unsigned cur,
                                               input int unsigned reload);
    if (level) return reload;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/ledovr_stretch.sv
module ledovr_stretch #(
  parameter int unsigned STRETCH_CYCLES = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic stretched_o
);
  import ledovr_pkg::*;

  localparam int unsigned CW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(STRETCH_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          hold_active;

  always_comb begin
    cnt_d = CW'(stretch_next(pulse_i, int'(cnt_q), STRETCH_CYCLES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hold_active = (cnt_q != '0);
  assign stretched_o = pulse_i | hold_active;

  AST_FALL_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_i) |-> stretched_o); // R5
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD); // R5
  AST_PULSE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> stretched_o); // R6

endmodule

// File: rtl/ledovr_regs.sv
module ledovr_regs #(
  parameter int unsigned    ADDR_W    = 12,
  parameter int unsigned    NUM_LEDS  = 8,
  parameter logic [11:0]    LED_OFFS  = 12'h00C,
  parameter logic [11:0]    CTRL_OFFS = 12'h014
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [ADDR_W-1:0]             paddr,
  input  logic [ledovr_pkg::BUS_W-1:0]  pwdata,
  output logic [ledovr_pkg::BUS_W-1:0]  prdata,
  output logic [NUM_LEDS-1:0]           led_q,
  output ledovr_pkg::led_src_e          src_sel
);
  import ledovr_pkg::*;

  localparam logic [ADDR_W-1:0] LED_A  = ADDR_W'(LED_OFFS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFFS);

  logic wr_access;
  logic hit_led;
  logic hit_ctrl;
  logic wr_led;
  logic wr_ctrl;

  assign wr_access = psel & penable & pwrite;
  assign hit_led   = (paddr == LED_A);
  assign hit_ctrl  = (paddr == CTRL_A);
  assign wr_led    = wr_access & hit_led;
  assign wr_ctrl   = wr_access & hit_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q   <= '0;
      src_sel <= SRC_SOFT;
    end else begin
      if (wr_led)  led_q   <= pwdata[NUM_LEDS-1:0];
      if (wr_ctrl) src_sel <= led_src_e'(pwdata[0]);
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (hit_led)       prdata = widen(BUS_W'(led_q), NUM_LEDS);
      else if (hit_ctrl) prdata = widen(BUS_W'(src_sel), 1);
    end
  end

  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_led |=> $stable(led_q)); // R1
  AST_LED_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_led |=> led_q == $past(pwdata[NUM_LEDS-1:0])); // R1
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(src_sel)); // R3
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> prdata[BUS_W-1:NUM_LEDS] == '0); // R7

endmodule

// File: rtl/ledovr_top.sv
module ledovr_top #(
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned NUM_LEDS       = 8,
  parameter int unsigned STRETCH_CYCLES = 1 << 20,
  parameter logic [11:0] LED_OFFS       = 12'h00C,
  parameter logic [11:0] CTRL_OFFS      = 12'h014
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [31:0]         pwdata,
  output logic [31:0]         prdata,
  output logic                pready,
  input  logic [NUM_LEDS-1:0] status_i,
  output logic [NUM_LEDS-1:0] led_o
);
  import ledovr_pkg::*;

  logic [NUM_LEDS-1:0] led_q;
  logic [NUM_LEDS-1:0] stretched;
  led_src_e            src_sel;

  ledovr_regs #(
    .ADDR_W(ADDR_W), .NUM_LEDS(NUM_LEDS), .LED_OFFS(LED_OFFS), .CTRL_OFFS(CTRL_OFFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .led_q(led_q), .src_sel(src_sel)
  );

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_line
    ledovr_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_str (
      .clk(clk), .rst_n(rst_n), .pulse_i(status_i[g]), .stretched_o(stretched[g])
    );
  end

  assign pready = 1'b1;
  assign led_o  = (src_sel == SRC_STATUS) ? stretched : led_q;

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> pready); // R8

endmodule

// File: tb/tb_ledovr_top.sv
module tb_ledovr_top;
  localparam int S = 12;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  st = 0;
  logic [7:0]  led_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] lref = 0;
  logic       mref = 0;
  int         cref [8];

  ledovr_top #(.STRETCH_CYCLES(S)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .status_i(st), .led_o(led_o)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] exp_led();
    logic [7:0] s;
    for (int i = 0; i < 8; i++) s[i] = st[i] || (cref[i] > 0);
    return mref ? s : lref;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a == 12'h00C) return {24'h0, lref};
    if (a == 12'h014) return {31'h0, mref};
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: model follows the edge, then outputs are compared at negedge
  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      lref = 0; mref = 0;
      for (int i = 0; i < 8; i++) cref[i] = 0;
    end else begin
      if (psel && penable && pwrite) begin
        if (paddr == 12'h00C) lref = pwdata[7:0];
        if (paddr == 12'h014) mref = pwdata[0];
      end
      for (int i = 0; i < 8; i++)
        cref[i] = st[i] ? S : (cref[i] > 0 ? cref[i] - 1 : 0);
    end
    @(negedge clk);
    check(mref ? "R4/R5 override view" : "R1 soft view", {24'h0, led_o}, {24'h0, exp_led()});
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    tick();
    penable = 1;
    tick();
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, input string req);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    tick();
    penable = 1;
    check("R8 ready", {31'h0, pready}, 32'h1);
    check(req, prdata, exp_rd(a));
    tick();
    psel = 0; penable = 0;
  endtask

  task automatic count_flash(input int bitn, input string req);
    int n = 0;
    while (led_o[bitn] && n < S + 5) begin n++; tick(); end
    check(req, n, S);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) cref[i] = 0;
    repeat (3) tick();
    check("R1 reset leds", {24'h0, led_o}, 32'h0);
    psel = 1; paddr = 12'h00C; @(negedge clk);
    check("R2 reset readback", prdata, 32'h0);
    paddr = 12'h014; @(negedge clk);
    check("R3 reset mode", prdata, 32'h0);
    psel = 0;
    rst_n = 1;
    tick();

    // R1/R2 normal mode writes, with busy status lines that must not show
    for (int k = 0; k < 20; k++) begin
      st = 8'($urandom);
      apb_wr(12'h00C, $urandom);
      apb_rd(12'h00C, "R2 readback");
    end
    st = 0;
    apb_wr(12'h00C, 32'hFFFF_FF00);
    apb_rd(12'h00C, "R2 upper bits dropped");
    apb_wr(12'h00C, 32'h0000_00A5);

    // R8 setup phase alone must not write
    psel = 1; pwrite = 1; paddr = 12'h00C; pwdata = 32'h3C; tick();
    psel = 0; pwrite = 0; tick();
    apb_rd(12'h00C, "R8 setup-only write ignored");

    // R7 unmapped offsets
    apb_wr(12'h010, 32'hFFFF_FFFF);
    apb_wr(12'h018, 32'hFFFF_FFFF);
    apb_wr(12'h00D, 32'hFFFF_FFFF);
    apb_rd(12'h010, "R7 unmapped read");
    apb_rd(12'h000, "R7 unmapped read");
    apb_rd(12'h00C, "R7 led reg untouched");
    apb_rd(12'h014, "R7 mode untouched");

    // R9 pulse while in normal mode, then switch to override
    st = 8'h20; tick(); st = 0; tick();
    apb_wr(12'h014, 32'hFFFF_FFFF);
    check("R9 stretch visible after switch", {31'h0, led_o[5]}, 32'h1);
    apb_rd(12'h014, "R3 mode readback");
    apb_rd(12'h00C, "R2 readback in override");
    repeat (S + 2) tick();

    // R5 single-cycle pulse on system reset request line
    st = 8'h08; tick(); st = 0;
    count_flash(3, "R5 flash length");
    // R5 long input
    st = 8'h01; repeat (7) tick(); st = 0;
    count_flash(0, "R5 hold after long input");
    // R6 restart mid-stretch
    st = 8'h04; tick(); st = 0; repeat (5) tick();
    st = 8'h04; tick(); st = 0;
    count_flash(2, "R6 restart full length");

    // R4 random sparse status, with occasional mode flips
    for (int k = 0; k < 600; k++) begin
      for (int i = 0; i < 8; i++) st[i] = ($urandom % 9) == 0;
      if ((k % 97) == 50) apb_wr(12'h014, {31'h0, 1'($urandom)});
      else tick();
    end
    st = 0;
    apb_wr(12'h014, 32'h0);
    apb_rd(12'h014, "R3 mode cleared");
    check("R1 soft view restored", {24'h0, led_o}, {24'h0, lref});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule